// File: doc/BRIEF.md
# Maskable Interrupt Request and Vector Controller

This block sits next to a small 8-bit processor core. It decides when the core must leave its normal instruction flow, and which 16-bit vector address the core fetches next.

An active-low external request pin goes through a two-flop synchronizer. It then passes a minimum-width qualifier counted in system clocks. A request that qualifies sets a request latch, and the latch captures the request even while it is masked. Two masks gate the latch output: the core's global I-bit and a per-source mask bit held in an 8-bit status/control register. A software can read the state of the latch from that register. It can also clear the latch by writing a one to a self-clearing acknowledge bit.

At each instruction-complete strobe the controller chooses between a pending software interrupt and the external request. Hardware requests that were already eligible when the software-interrupt opcode was fetched are served first. A reset request overrides everything and does not wait for an instruction boundary.

When the controller takes an interrupt, it issues a one-clock take strobe together with the matching fixed vector address:

| Source | Vector address |
|---|---|
| Reset | 0x1FFE |
| Software interrupt | 0x1FFC |
| External request | 0x1FFA |

Top module: `irq_vector_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are in this state:
  - `take` is 0 and `ibit_set` is 0.
  - `vec_addr` is 0x1FFE.
  - `reg_rdata` is 0x01, which means the mask bit (bit 0) is set and the request flag (bit 7) is clear.
- R2: The external request sets the latch only if `irq_n` is held low for at least MIN_PULSE consecutive clocks (default 4). A low lasting MIN_PULSE-1 clocks leaves the latch clear. One low episode sets the latch at most once.
- R3: The latch captures a qualified request whatever the state of the I-bit or the mask bit. Its state always reads back in bit 7 of `reg_rdata`.
- R4: An external interrupt is taken only at an instruction boundary. Taking it needs three conditions at the boundary:
  - the latch is 1,
  - `ibit` is 0,
  - the mask bit is 0.
  The take cycle follows this rule: `take` rises one clock after `instr_done` and stays high for exactly one clock, with `vec_addr` = 0x1FFA.
- R5: Taking the external interrupt clears the latch, so bit 7 of `reg_rdata` reads 0 afterwards.
- R6: A register write with bit 1 set clears the latch. Bit 1 is not stored and always reads 0.
- R7: If a qualified request arrives in the same clock as an acknowledge write, the latch ends up set.
- R8: After `swi_strobe`, the next instruction boundary takes the software interrupt (`vec_addr` = 0x1FFC) whatever the value of `ibit`. The one exception is the case covered by R9.
- R9: Ordering between a software interrupt and an external request depends on when the external request became eligible:
  - If the request was eligible (latched, unmasked, I-bit clear) at the cycle of `swi_strobe`, the external interrupt is taken at the first boundary and the software interrupt at the next.
  - If the request became eligible later, the software interrupt goes first.
- R10: A rising edge on `reset_req` produces one take with `vec_addr` = 0x1FFE and `ibit_set` = 1 on the next clock, with or without `instr_done`. It has priority over every other source, and it cancels any pending software interrupt. It also clears the latch and sets the mask bit. Holding `reset_req` high produces no further takes.
- R11: Bit 0 of a register write is stored as the per-source mask and reads back in bit 0 of `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | External interrupt request, active low, asynchronous |
| reset_req | input | 1 | Reset request from pin logic or an internal source, active high |
| swi_strobe | input | 1 | One-clock pulse when a software-interrupt opcode is fetched |
| instr_done | input | 1 | One-clock pulse at each instruction boundary |
| ibit | input | 1 | Global interrupt mask from the core condition codes |
| reg_wr | input | 1 | Status/control register write enable |
| reg_wdata | input | 8 | Register write data: bit 0 is the mask, bit 1 is the acknowledge |
| take | output | 1 | One-clock strobe: start the interrupt sequence |
| vec_addr | output | 16 | Address of the high byte of the selected vector |
| ibit_set | output | 1 | One-clock strobe with a reset take: the core must set its I-bit |
| reg_rdata | output | 8 | Register read value: bit 7 is the request flag, bit 0 is the mask |

## Verification
A vector table tries every combination of the I-bit and the mask bit with a qualifying low pulse. This shows that capture is independent of masking while the take depends on both masks. The table also applies a pulse one clock short of the minimum and one well above it, which checks the exact qualification boundary. Directed sequences then place the software strobe before and after an external request becomes eligible, which separates the two orderings. A software interrupt raised while the I-bit is set shows that the software path is never blocked. Finally, an acknowledge write lands in the very clock a new request qualifies, and a reset request arrives with both other sources pending, which checks the two precedence rules.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RST  = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_IRQ  = 2'd3
  } src_e;

  localparam int REG_W    = 8;
  localparam int MASK_BIT = 0;
  localparam int ACK_BIT  = 1;
  localparam int PEND_BIT = 7;
endpackage

// File: rtl/irq_pulse_qual.sv
module irq_pulse_qual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic hit
);
  localparam int CNT_W = $clog2(MIN_PULSE + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             low;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], pin_n};
  end

  assign low = !sync_q[1];

  // count consecutive low clocks, saturating at the minimum
  always_ff @(posedge clk) begin
    if (rst || !low)                       cnt_q <= '0;
    else if (cnt_q != CNT_W'(MIN_PULSE))   cnt_q <= cnt_q + 1'b1;
  end

  assign hit = low && (cnt_q == CNT_W'(MIN_PULSE - 1));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(MIN_PULSE));

  // R2
  hit_once_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic hit,
  input  logic ack,
  input  logic take_irq,
  input  logic mask_wr,
  input  logic mask_wdata,
  output logic latch_q,
  output logic mask_q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst)       latch_q <= 1'b0;
    else if (hit)              latch_q <= 1'b1;
    else if (ack || take_irq)  latch_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) mask_q <= 1'b1;
    else if (mask_wr)    mask_q <= mask_wdata;
  end

  // R7
  new_req_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit && !soft_rst |=> latch_q);

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack && !hit |=> !latch_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter logic [15:0] VEC_RST = 16'h1FFE,
  parameter logic [15:0] VEC_SWI = 16'h1FFC,
  parameter logic [15:0] VEC_IRQ = 16'h1FFA
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rst_edge,
  input  logic        swi_strobe,
  input  logic        instr_done,
  input  logic        ibit,
  input  logic        latch_q,
  input  logic        mask_q,
  output logic        take_irq,
  output logic        take,
  output logic [15:0] vec_addr,
  output logic        ibit_set
);
  logic swi_pend_q;
  logic hw_first_q;
  logic hw_ok;
  src_e sel;

  assign hw_ok = latch_q && !ibit && !mask_q;

  always_comb begin
    sel = SRC_NONE;
    if (rst_edge)                                sel = SRC_RST;
    else if (instr_done) begin
      if (swi_pend_q && hw_first_q && hw_ok)     sel = SRC_IRQ;
      else if (swi_pend_q)                       sel = SRC_SWI;
      else if (hw_ok)                            sel = SRC_IRQ;
    end
  end

  assign take_irq = (sel == SRC_IRQ);

  always_ff @(posedge clk) begin
    if (rst || rst_edge)        swi_pend_q <= 1'b0;
    else if (swi_strobe)        swi_pend_q <= 1'b1;
    else if (sel == SRC_SWI)    swi_pend_q <= 1'b0;
  end

  // remember whether hardware was already eligible when the SWI was fetched
  always_ff @(posedge clk) begin
    if (rst || rst_edge)        hw_first_q <= 1'b0;
    else if (swi_strobe)        hw_first_q <= hw_ok;
    else if (sel != SRC_NONE)   hw_first_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      ibit_set <= 1'b0;
      vec_addr <= VEC_RST;
    end else begin
      take     <= (sel != SRC_NONE);
      ibit_set <= (sel == SRC_RST);
      case (sel)
        SRC_RST: vec_addr <= VEC_RST;
        SRC_SWI: vec_addr <= VEC_SWI;
        SRC_IRQ: vec_addr <= VEC_IRQ;
        default: vec_addr <= vec_addr;
      endcase
    end
  end

  // R10
  reset_take_chk: assert property (@(posedge clk) disable iff (rst)
    rst_edge |=> take && ibit_set && (vec_addr == VEC_RST));

  // R8
  swi_take_chk: assert property (@(posedge clk) disable iff (rst)
    instr_done && !rst_edge && swi_pend_q && !hw_first_q |=> take && (vec_addr == VEC_SWI));

  // R4
  idle_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_edge && !instr_done |=> !take);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int          MIN_PULSE = 4,
  parameter logic [15:0] VEC_RST   = 16'h1FFE,
  parameter logic [15:0] VEC_SWI   = 16'h1FFC,
  parameter logic [15:0] VEC_IRQ   = 16'h1FFA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_n,
  input  logic             reset_req,
  input  logic             swi_strobe,
  input  logic             instr_done,
  input  logic             ibit,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             take,
  output logic [15:0]      vec_addr,
  output logic             ibit_set,
  output logic [REG_W-1:0] reg_rdata
);
  logic reset_req_q;
  logic rst_edge;
  logic hit;
  logic ack;
  logic take_irq;
  logic latch_q;
  logic mask_q;

  always_ff @(posedge clk) begin
    if (rst) reset_req_q <= 1'b0;
    else     reset_req_q <= reset_req;
  end

  assign rst_edge = reset_req && !reset_req_q;
  assign ack      = reg_wr && reg_wdata[ACK_BIT];

  irq_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .pin_n (irq_n),
    .hit   (hit)
  );

  irq_req_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (rst_edge),
    .hit        (hit),
    .ack        (ack),
    .take_irq   (take_irq),
    .mask_wr    (reg_wr),
    .mask_wdata (reg_wdata[MASK_BIT]),
    .latch_q    (latch_q),
    .mask_q     (mask_q)
  );

  irq_arbiter #(
    .VEC_RST (VEC_RST),
    .VEC_SWI (VEC_SWI),
    .VEC_IRQ (VEC_IRQ)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .rst_edge   (rst_edge),
    .swi_strobe (swi_strobe),
    .instr_done (instr_done),
    .ibit       (ibit),
    .latch_q    (latch_q),
    .mask_q     (mask_q),
    .take_irq   (take_irq),
    .take       (take),
    .vec_addr   (vec_addr),
    .ibit_set   (ibit_set)
  );

  always_comb begin
    reg_rdata           = '0;
    reg_rdata[PEND_BIT] = latch_q;
    reg_rdata[MASK_BIT] = mask_q;
  end

  // R4
  irq_needs_clear_ibit_chk: assert property (@(posedge clk) disable iff (rst)
    take && (vec_addr == VEC_IRQ) |-> !$past(ibit) && !$past(mask_q));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int MIN = 4;
  localparam logic [15:0] V_RST = 16'h1FFE;
  localparam logic [15:0] V_SWI = 16'h1FFC;
  localparam logic [15:0] V_IRQ = 16'h1FFA;

  // {ibit, mask, pulse_len[7:0], exp_req, exp_take}
  localparam logic [11:0] TBL [6] = '{
    {1'b0, 1'b0, 8'(MIN),     1'b1, 1'b1},
    {1'b1, 1'b0, 8'(MIN),     1'b1, 1'b0},
    {1'b0, 1'b1, 8'(MIN),     1'b1, 1'b0},
    {1'b1, 1'b1, 8'(MIN),     1'b1, 1'b0},
    {1'b0, 1'b0, 8'(MIN - 1), 1'b0, 1'b0},
    {1'b0, 1'b0, 8'(MIN + 5), 1'b1, 1'b1}
  };

  logic clk = 0, rst = 1, irq_n = 1, reset_req = 0, swi = 0, done = 0, ibit = 0, wr = 0;
  logic [7:0]  wdata = 0;
  logic        take, ibit_set;
  logic [15:0] vec;
  logic [7:0]  rdata;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_vector_ctrl #(.MIN_PULSE(MIN)) uut (
    .clk(clk), .rst(rst), .irq_n(irq_n), .reset_req(reset_req), .swi_strobe(swi),
    .instr_done(done), .ibit(ibit), .reg_wr(wr), .reg_wdata(wdata),
    .take(take), .vec_addr(vec), .ibit_set(ibit_set), .reg_rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); wr = 1; wdata = d;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq_n = 0;
    repeat (n) @(negedge clk);
    irq_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic strobe_swi();
    @(negedge clk); swi = 1;
    @(negedge clk); swi = 0;
  endtask

  task automatic boundary(input string tag, input logic exp_take, input logic [15:0] exp_vec);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    chk({tag, " take"}, 32'(take), 32'(exp_take));
    if (exp_take) chk({tag, " vector"}, 32'(vec), 32'(exp_vec));
    @(negedge clk);
    chk({tag, " take width"}, 32'(take), 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 take", 32'(take), 0);
    chk("R1 ibit_set", 32'(ibit_set), 0);
    chk("R1 vector", 32'(vec), 32'(V_RST));
    chk("R1 rdata", 32'(rdata), 32'h01);

    // R2 R3 R4 R5 table walk
    for (int i = 0; i < 6; i++) begin
      logic [11:0] e;
      e = TBL[i];
      ibit = 0;
      wr_reg(8'h02 | {7'b0, e[10]});
      ibit = e[11];
      pulse(int'(e[9:2]));
      chk($sformatf("R2/R3 row%0d request flag", i), 32'(rdata[7]), 32'(e[1]));
      boundary($sformatf("R4 row%0d", i), e[0], V_IRQ);
      if (e[0]) chk($sformatf("R5 row%0d flag cleared", i), 32'(rdata[7]), 0);
    end
    ibit = 0;

    // R11 mask storage
    wr_reg(8'h00); chk("R11 mask clear", 32'(rdata), 32'h00);
    wr_reg(8'h01); chk("R11 mask set", 32'(rdata), 32'h01);

    // R6 acknowledge clears, reads zero
    pulse(MIN);
    chk("R6 setup flag", 32'(rdata[7]), 1);
    wr_reg(8'h03);
    chk("R6 ack cleared flag", 32'(rdata[7]), 0);
    chk("R6 ack bit reads 0", 32'(rdata[1]), 0);

    // R7 request and acknowledge in same clock
    pulse(MIN);
    @(negedge clk); irq_n = 0;
    repeat (MIN + 1) @(negedge clk);
    wr = 1; wdata = 8'h03;
    @(negedge clk); wr = 0; wdata = 0;
    chk("R7 new request kept", 32'(rdata[7]), 1);
    repeat (3) @(negedge clk); irq_n = 1;
    repeat (4) @(negedge clk);
    wr_reg(8'h02);  // clear, unmask

    // R9 hardware eligible before SWI fetch goes first
    pulse(MIN);
    strobe_swi();
    boundary("R9 pending hw first", 1, V_IRQ);
    boundary("R9 then swi", 1, V_SWI);
    boundary("R9 nothing left", 0, V_RST);

    // R9 hardware arriving after SWI fetch goes second
    strobe_swi();
    pulse(MIN);
    boundary("R9 swi first", 1, V_SWI);
    boundary("R9 late hw second", 1, V_IRQ);

    // R8 SWI ignores I-bit; hardware blocked, still latched
    ibit = 1;
    pulse(MIN);
    strobe_swi();
    boundary("R8 swi with ibit", 1, V_SWI);
    boundary("R8 hw blocked by ibit", 0, V_RST);
    chk("R3 flag held under ibit", 32'(rdata[7]), 1);

    // R10 reset request overrides everything
    ibit = 0;
    strobe_swi();
    @(negedge clk); reset_req = 1; done = 1;
    @(negedge clk); done = 0;
    chk("R10 take", 32'(take), 1);
    chk("R10 vector", 32'(vec), 32'(V_RST));
    chk("R10 ibit_set", 32'(ibit_set), 1);
    chk("R10 rdata restored", 32'(rdata), 32'h01);
    @(negedge clk);
    chk("R10 held request no retake", 32'(take), 0);
    reset_req = 0;
    wr_reg(8'h00);
    boundary("R10 swi cancelled", 0, V_RST);

    summary();
  end
endmodule